// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves data between system memory and a single peripheral's FIFO. Software describes two memory regions, A-side and B-side (internally buffer 0 and buffer 1). Each has its own start address and a 16-bit count in device-width units. The channel then services whichever region is active. When one region drains, it marks that region finished and moves on to the other if the other is armed. Software can refill the idle region while the busy one runs, so a stream continues without gaps.

Control is a small register bank on a 32-bit bus, with writes taking effect on the clock edge and reads returning data combinationally. The control word is changed through two write offsets: one sets the written ones and the other clears them. Status is read back through the same word. This status covers the finished flags, the active-region bit and a stopped indication that confirms a stop request has taken effect. Each unit moved waits for the peripheral's request and for the memory handshake. The data lanes can optionally be byte-reversed within the device width. An interrupt line reports finished regions.

Top module: `pingpong_dma`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x0000_0040 (only the stopped bit set), the FIFO address, both starts and both counts read 0, `irq` is 0 and `mem_valid` is 0.
- R2: Control word bits: 0 arm-0, 1 fin-0, 2 arm-1, 3 fin-1, 4 active region, 5 run, 6 stopped, 7 irq enable, 8 non-coherent, 10:9 device width, 11 burst-of-8, 12 direction, 13 byte reverse, 15 ID bank, 19:16 device ID. A write to 0x00 ORs ones into bits 0, 2, 5, 7–13, 15 and 16–19. A write to 0x04 clears the written ones in those bits and in bits 1 and 3. Bits 1, 3, 4 and 6 cannot be set by software, and bit 14 reads 0. Offset 0x08 holds the FIFO address driven on `dev_fifo_addr`. Offsets 0x0C/0x10 hold start/count of buffer 0, and 0x14/0x18 hold start/count of buffer 1.
- R3: While run is set and the active buffer is armed with a nonzero count, an asserted `dev_req` raises `mem_valid` at the active buffer's current address. Each cycle with `mem_valid` and `mem_ready` both high decrements that count by one. It also advances the address by 1, 2 or 4 for width codes 0, 1 and 2 (code 3 acts as 4), and pulses `dev_ack`.
- R4: Once raised, `mem_valid` stays high with `mem_addr` unchanged until `mem_ready` is seen.
- R5: With bit 12 at 1 the transfer is peripheral-to-memory: `mem_write` is 1 and `mem_wdata` comes from `dev_rdata`. With bit 12 at 0 it is a memory read and `dev_wdata` comes from `mem_rdata`.
- R6: With bit 13 set, data in either direction has its bytes reversed within the device width. A 16-bit width swaps bytes 0 and 1, a 32-bit width reverses all four bytes, and an 8-bit width leaves the data unchanged.
- R7: When the active buffer's count is zero while running, its fin bit is set and its arm bit is cleared. The active bit then flips to the other buffer if that buffer is armed.
- R8: Bit 4 reads 0 while buffer 0 is serviced and 1 for buffer 1. The active buffer's start and count registers read back their live, advancing values.
- R9: Bit 6 reads 1 whenever the channel is not servicing an armed buffer under run and no handshake is in flight. After software clears run, an in-flight handshake completes, no new request starts and bit 6 then reads 1.
- R10: With run set and no buffer armed the channel idles with bit 6 at 1. Arming the inactive buffer flips the active bit to it and servicing resumes.
- R11: A fin bit stays set until a one is written to its position at 0x04. `irq` is high exactly when bit 7 and at least one fin bit are set.
- R12: While the channel is servicing a buffer or a handshake is in flight, writes to that buffer's start and count are ignored. Writes to the other buffer's registers take effect, and count writes keep the low 16 bits.
- R13: With `dev_req` low no memory request is raised and the counts do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dev_req | input | 1 | Peripheral transfer request |
| dev_ack | output | 1 | Pulse when a unit has been moved |
| dev_fifo_addr | output | 32 | Fixed peripheral FIFO address |
| dev_rdata | input | 32 | Data from the peripheral FIFO |
| dev_wdata | output | 32 | Data to the peripheral FIFO |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_size | output | 2 | Access size code: 0 byte, 1 half, 2 word |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory handshake complete |
| irq | output | 1 | Interrupt |

## Verification
The hardest states to reach are those where software acts while a handshake is half done. One is a stop request landing while the memory side is stalled. Another is a register write aimed at the buffer being drained. The bench reaches both by holding back its memory model's ready and by pausing the peripheral request, so the channel sits in a known state at a register write. It then checks that the in-flight unit still completes before the stopped bit rises, and that the locked buffer's counters move only by transfers. A gap-free hand-over between the two buffers comes from arming both buffers before run is set. An idle channel with run set is resumed by arming only the inactive buffer.

// File: rtl/pingpong_dma.sv
module pingpong_dma #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           dev_req,
  output logic           dev_ack,
  output logic [AW-1:0]  dev_fifo_addr,
  input  logic [31:0]    dev_rdata,
  output logic [31:0]    dev_wdata,
  output logic           mem_valid,
  output logic           mem_write,
  output logic [1:0]     mem_size,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_ready,
  output logic           irq
);

  localparam logic [RAW-1:0] OFS_SET  = RAW'(5'h00);
  localparam logic [RAW-1:0] OFS_CLR  = RAW'(5'h04);
  localparam logic [RAW-1:0] OFS_FIFO = RAW'(5'h08);
  localparam logic [RAW-1:0] OFS_ST0  = RAW'(5'h0C);
  localparam logic [RAW-1:0] OFS_CT0  = RAW'(5'h10);
  localparam logic [RAW-1:0] OFS_ST1  = RAW'(5'h14);
  localparam logic [RAW-1:0] OFS_CT1  = RAW'(5'h18);

  logic en0, en1, dn0, dn1, ab, go, ie, nc, ts8, dir, bswap, bank;
  logic [1:0]    wid;
  logic [3:0]    devid;
  logic [AW-1:0] fifo_q, st0, st1;
  logic [CW-1:0] ct0, ct1;
  logic          infl;

  logic          en_act, en_oth, run, xfer, cmp, halt, lock, flip_idle;
  logic [CW-1:0] cnt_act;
  logic [AW-1:0] inc;
  logic          wr_set, wr_clr;
  logic [31:0]   mode_w;

  function automatic logic [31:0] lane_rev(input logic [31:0] d, input logic [1:0] w);
    case (w)
      2'd0:    lane_rev = d;
      2'd1:    lane_rev = {d[31:16], d[7:0], d[15:8]};
      default: lane_rev = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  assign en_act    = ab ? en1 : en0;
  assign en_oth    = ab ? en0 : en1;
  assign cnt_act   = ab ? ct1 : ct0;
  assign run       = go & en_act;
  assign mem_valid = infl | (run & (cnt_act != '0) & dev_req);
  assign xfer      = mem_valid & mem_ready;
  assign cmp       = run & (cnt_act == '0) & ~infl;
  assign halt      = ~run & ~infl;
  assign lock      = run | infl;
  assign flip_idle = go & ~en_act & en_oth & ~infl;
  assign inc       = (wid == 2'd0) ? AW'(1) : (wid == 2'd1) ? AW'(2) : AW'(4);

  assign wr_set = reg_we & (reg_addr == OFS_SET);
  assign wr_clr = reg_we & (reg_addr == OFS_CLR);

  assign mem_addr      = ab ? st1 : st0;
  assign mem_write     = dir;
  assign mem_size      = (wid == 2'd3) ? 2'd2 : wid;
  assign mem_wdata     = bswap ? lane_rev(dev_rdata, wid) : dev_rdata;
  assign dev_wdata     = bswap ? lane_rev(mem_rdata, wid) : mem_rdata;
  assign dev_ack       = xfer;
  assign dev_fifo_addr = fifo_q;
  assign irq           = ie & (dn0 | dn1);

  assign mode_w = {12'd0, devid, bank, 1'b0, bswap, dir, ts8, wid, nc, ie,
                   halt, go, ab, dn1, en1, dn0, en0};

  always_comb begin
    case (reg_addr)
      OFS_SET:  reg_rdata = mode_w;
      OFS_FIFO: reg_rdata = 32'(fifo_q);
      OFS_ST0:  reg_rdata = 32'(st0);
      OFS_CT0:  reg_rdata = 32'(ct0);
      OFS_ST1:  reg_rdata = 32'(st1);
      OFS_CT1:  reg_rdata = 32'(ct1);
      default:  reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en0, en1, dn0, dn1, ab, go, ie, nc, ts8, dir, bswap, bank} <= '0;
      wid   <= '0;
      devid <= '0;
      infl  <= 1'b0;
    end else begin
      infl <= mem_valid & ~mem_ready;
      if (wr_set) begin
        en0   <= en0   | reg_wdata[0];
        en1   <= en1   | reg_wdata[2];
        go    <= go    | reg_wdata[5];
        ie    <= ie    | reg_wdata[7];
        nc    <= nc    | reg_wdata[8];
        wid   <= wid   | reg_wdata[10:9];
        ts8   <= ts8   | reg_wdata[11];
        dir   <= dir   | reg_wdata[12];
        bswap <= bswap | reg_wdata[13];
        bank  <= bank  | reg_wdata[15];
        devid <= devid | reg_wdata[19:16];
      end
      if (wr_clr) begin
        en0   <= en0   & ~reg_wdata[0];
        dn0   <= dn0   & ~reg_wdata[1];
        en1   <= en1   & ~reg_wdata[2];
        dn1   <= dn1   & ~reg_wdata[3];
        go    <= go    & ~reg_wdata[5];
        ie    <= ie    & ~reg_wdata[7];
        nc    <= nc    & ~reg_wdata[8];
        wid   <= wid   & ~reg_wdata[10:9];
        ts8   <= ts8   & ~reg_wdata[11];
        dir   <= dir   & ~reg_wdata[12];
        bswap <= bswap & ~reg_wdata[13];
        bank  <= bank  & ~reg_wdata[15];
        devid <= devid & ~reg_wdata[19:16];
      end
      if (cmp) begin
        if (ab) begin
          en1 <= 1'b0;
          dn1 <= 1'b1;
        end else begin
          en0 <= 1'b0;
          dn0 <= 1'b1;
        end
        if (en_oth) ab <= ~ab;
      end else if (flip_idle) begin
        ab <= ~ab;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_q <= '0;
      st0    <= '0;
      st1    <= '0;
      ct0    <= '0;
      ct1    <= '0;
    end else begin
      if (reg_we && reg_addr == OFS_FIFO) fifo_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == OFS_ST0 && !(lock && !ab)) st0 <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == OFS_CT0 && !(lock && !ab)) ct0 <= reg_wdata[CW-1:0];
      if (reg_we && reg_addr == OFS_ST1 && !(lock && ab))  st1 <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == OFS_CT1 && !(lock && ab))  ct1 <= reg_wdata[CW-1:0];
      if (xfer) begin
        if (ab) begin
          st1 <= st1 + inc;
          ct1 <= ct1 - CW'(1);
        end else begin
          st0 <= st0 + inc;
          ct0 <= ct0 - CW'(1);
        end
      end
    end
  end

  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && run) |=> (cnt_act == $past(cnt_act) - CW'(1)));

  // R11
  fin_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn0 && !(wr_clr && reg_wdata[1])) |=> dn0);

  // R7
  fin_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && !ab) |=> (dn0 && !en0));

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !mem_valid && !(wr_set && reg_wdata[5])) |=> !mem_valid);

endmodule

// File: tb/tb_pingpong_dma.sv
module tb_pingpong_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_req = 1'b0;
  logic        dev_ack;
  logic [31:0] dev_fifo_addr;
  logic [31:0] dev_rdata = 32'h11223344;
  logic [31:0] dev_wdata;
  logic        mem_valid, mem_write;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;
  logic        irq;
  logic        mem_gate = 1'b1;

  int nchk = 0;
  int nerr = 0;
  int nlog = 0;
  logic [31:0] la[64];
  logic [31:0] ld[64];
  logic        lw[64];

  always #4 clk = ~clk;

  pingpong_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_fifo_addr(dev_fifo_addr), .dev_rdata(dev_rdata),
    .dev_wdata(dev_wdata), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
  );

  assign mem_rdata = mem_addr ^ 32'hC0DE0000;

  always @(posedge clk) begin
    if (!rst_n) mem_ready <= 1'b0;
    else mem_ready <= mem_valid && !mem_ready && mem_gate;
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (nlog < 64) begin
        la[nlog] = mem_addr;
        lw[nlog] = mem_write;
        ld[nlog] = mem_write ? mem_wdata : dev_wdata;
      end
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dev_req = 1'b0; mem_gate = 1'b1; reg_we = 1'b0;
    dev_rdata = 32'h11223344;
    repeat (3) @(negedge clk);
    nlog = 0;
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_bits(input logic [31:0] m, input string r);
    logic [31:0] v;
    bit seen = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      rd(5'h00, v);
      if ((v & m) == m) begin
        seen = 1'b1;
        break;
      end
    end
    chk({r, " wait"}, 32'(seen), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(5'h00, v); chk("R1 mode", v, 32'h40);
    rd(5'h08, v); chk("R1 fifo", v, 0);
    rd(5'h0C, v); chk("R1 st0", v, 0);
    rd(5'h10, v); chk("R1 ct0", v, 0);
    rd(5'h14, v); chk("R1 st1", v, 0);
    rd(5'h18, v); chk("R1 ct1", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr(5'h00, 32'hFFFF_FFDA);
    rd(5'h00, v); chk("R2 set port", v, 32'h000F_BFC0);
    wr(5'h04, 32'h0000_3F00);
    rd(5'h00, v); chk("R2 clear port", v, 32'h000F_80C0);
    wr(5'h08, 32'h1000_0040);
    rd(5'h08, v); chk("R2 fifo reg", v, 32'h1000_0040);
    chk("R2 fifo pin", dev_fifo_addr, 32'h1000_0040);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    do_reset();
    wr(5'h0C, 32'h100);
    wr(5'h10, 32'h3);
    wr(5'h00, 32'h421);
    repeat (5) @(negedge clk);
    chk("R13 no request", 32'(mem_valid), 0);
    rd(5'h10, v); chk("R13 count held", v, 3);
    dev_req = 1'b1;
    wait_bits(32'h2, "R7 fin0");
    chk("R3 unit count", nlog, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 address", la[i], 32'h100 + 4 * i);
      chk("R5 read dir", 32'(lw[i]), 0);
      chk("R5 dev data", ld[i], (32'h100 + 4 * i) ^ 32'hC0DE0000);
    end
    rd(5'h00, v); chk("R7 mode after", v, 32'h462);
    rd(5'h0C, v); chk("R8 start live", v, 32'h10C);
    rd(5'h10, v); chk("R8 count live", v, 0);
  endtask

  task automatic t_pingpong();
    logic [31:0] v;
    do_reset();
    wr(5'h0C, 32'h200); wr(5'h10, 32'h2);
    wr(5'h14, 32'h300); wr(5'h18, 32'h2);
    dev_req = 1'b1;
    wr(5'h00, 32'h2A5);
    wait_bits(32'hA, "R7 both fin");
    chk("R7 unit count", nlog, 4);
    chk("R7 order a", la[0], 32'h200);
    chk("R3 half step", la[1], 32'h202);
    chk("R7 order b", la[2], 32'h300);
    chk("R7 order c", la[3], 32'h302);
    rd(5'h00, v); chk("R8 active one", v, 32'h2FA);
    chk("R11 irq on", 32'(irq), 1);
    wr(5'h04, 32'h2);
    chk("R11 irq one fin", 32'(irq), 1);
    wr(5'h00, 32'hA);
    rd(5'h00, v); chk("R2 fin not settable", v, 32'h2F8);
    wr(5'h04, 32'h8);
    chk("R11 irq off", 32'(irq), 0);
    rd(5'h00, v); chk("R11 cleared", v, 32'h2F0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(5'h0C, 32'h400); wr(5'h10, 32'd10);
    wr(5'h14, 32'h500); wr(5'h18, 32'd1);
    wr(5'h00, 32'h421);
    wr(5'h10, 32'h55);
    wr(5'h0C, 32'h999);
    wr(5'h18, 32'h1_0007);
    wr(5'h14, 32'h600);
    rd(5'h10, v); chk("R12 active count locked", v, 10);
    rd(5'h0C, v); chk("R12 active start locked", v, 32'h400);
    rd(5'h18, v); chk("R12 other count 16b", v, 7);
    rd(5'h14, v); chk("R12 other start", v, 32'h600);
    dev_req = 1'b1;
    while (nlog < 4) @(negedge clk);
    dev_req = 1'b0;
    repeat (6) @(negedge clk);
    rd(5'h10, v); chk("R8 live count", v, 32'(10 - nlog));
    rd(5'h0C, v); chk("R8 live start", v, 32'h400 + 4 * nlog);
    rd(5'h00, v); chk("R8 active zero", v & 32'h10, 0);
  endtask

  task automatic t_halt();
    logic [31:0] v, a0, c0;
    do_reset();
    wr(5'h0C, 32'h800); wr(5'h10, 32'd200);
    dev_req = 1'b1;
    wr(5'h00, 32'h421);
    repeat (8) @(negedge clk);
    rd(5'h00, v); chk("R9 running", v & 32'h40, 0);
    mem_gate = 1'b0;
    repeat (2) @(negedge clk);
    a0 = mem_addr;
    wr(5'h04, 32'h20);
    repeat (2) @(negedge clk);
    rd(5'h00, v); chk("R9 in flight", v & 32'h40, 0);
    chk("R4 held valid", 32'(mem_valid), 1);
    chk("R4 held addr", mem_addr, a0);
    mem_gate = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'h00, v); chk("R9 stopped", v & 32'h40, 32'h40);
    chk("R9 no request", 32'(mem_valid), 0);
    rd(5'h10, c0);
    chk("R9 count matches", c0, 32'(200 - nlog));
    repeat (10) @(negedge clk);
    rd(5'h10, v); chk("R9 count frozen", v, c0);
  endtask

  task automatic t_resume();
    logic [31:0] v;
    do_reset();
    wr(5'h00, 32'h420);
    repeat (3) @(negedge clk);
    rd(5'h00, v); chk("R10 idle stopped", v, 32'h460);
    chk("R10 idle quiet", 32'(mem_valid), 0);
    wr(5'h14, 32'hA00); wr(5'h18, 32'h2);
    dev_req = 1'b1;
    wr(5'h00, 32'h4);
    wait_bits(32'h8, "R10 fin1");
    chk("R10 units", nlog, 2);
    chk("R10 addr a", la[0], 32'hA00);
    chk("R10 addr b", la[1], 32'hA04);
    rd(5'h00, v); chk("R10 mode", v, 32'h478);
  endtask

  task automatic t_swap();
    do_reset();
    wr(5'h0C, 32'hC00); wr(5'h10, 32'h2);
    dev_req = 1'b1;
    wr(5'h00, 32'h3021);
    wait_bits(32'h2, "R6 byte run");
    chk("R3 byte step a", la[0], 32'hC00);
    chk("R3 byte step b", la[1], 32'hC01);
    chk("R5 write dir", 32'(lw[0]), 1);
    chk("R6 8b unchanged", ld[0], 32'h11223344);
    do_reset();
    wr(5'h0C, 32'hD00); wr(5'h10, 32'h1);
    dev_req = 1'b1;
    wr(5'h00, 32'h3421);
    wait_bits(32'h2, "R6 word run");
    chk("R6 32b reversed", ld[0], 32'h44332211);
    chk("R5 word write", 32'(lw[0]), 1);
    do_reset();
    wr(5'h0C, 32'hE00); wr(5'h10, 32'h1);
    dev_req = 1'b1;
    wr(5'h00, 32'h2221);
    wait_bits(32'h2, "R6 half run");
    chk("R6 16b swapped", ld[0], 32'hC0DE000E);
    chk("R5 half read", 32'(lw[0]), 0);
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_basic();
    t_pingpong();
    t_lock();
    t_halt();
    t_resume();
    t_swap();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule